// File: doc/BRIEF.md
# Flash Erase Suspend Controller

This block sequences the erase-side commands of a NOR-style flash device. Commands arrive on a write-strobed bus that carries an 8-bit code, a word address and a data word. The block runs block erase, blank check and word program against a small array model, and reports progress through an 8-bit status register. Array reads go through a separate read strobe.

An erase is a fixed number of steps, and each step lasts a set number of clock cycles. A suspend request is only honoured at the end of a step. While an erase is suspended, the block accepts a defined set of commands and refuses any array access aimed at the suspended block. When the erase resumes, it continues from the step where it stopped. A program started during the suspend must finish before a pending resume takes effect.

The array is reset to all ones, which is the erased state. Every refused command or read produces a one-cycle pulse on `cmd_reject`.

Top module: `fec_flash_ctrl`

## Requirements
- R1: Status bit 7 is 0 while an erase, blank check or program is running and 1 otherwise. The status register reads 0x80 after reset.
- R2: Writing 0x20 and then 0xD0 erases the block addressed by the 0xD0 write, setting every word of it to all ones. If any code other than 0xD0 follows 0x20, the second write is rejected and no erase starts.
- R3: Writing 0xBC and then 0xD0 starts a blank check of the addressed block. If any word in that block is not all ones, status bit 5 is set; if the block is blank, bit 5 is left unchanged.
- R4: Suspend (0xB0) is accepted at any address during an erase, but takes effect only at the next step boundary. Until then status bits 7 and 6 stay 0. Once suspended, both bits read 1.
- R5: While suspended, only 0xFF, 0x70, 0x90, 0x98, 0xD0, 0x50, 0x40, 0xB0 and 0x60 are accepted. Any other code is rejected, and the erase stays suspended.
- R6: While suspended, an array read or a program aimed at the suspended block is rejected. A rejected read returns 0 and a rejected program leaves the word unchanged. Other blocks can be read and programmed normally.
- R7: Resume (0xD0 while suspended, any address) clears status bits 7 and 6 at once, and the erase then completes from its stored step. If a program is still running, the resume is held until that program completes.
- R8: If the programming-voltage-low flag is set during an erase, the erase stops, status bit 3 is set and the block is left as it was. A program started while the flag is set is not performed and also sets bit 3.
- R9: Error bits 5 and 3 stay set until Clear Status (0x50) is written.
- R10: Reset aborts any operation, including a suspended erase, and returns the controller to idle. After reset, 0xD0 is rejected.
- R11: Writing 0x40 and then a data word programs the addressed word. After the program time, the word holds its old value ANDed with the data.
- R12: 0xFF selects array reads. 0x70, 0x90 and 0x98 select status reads, as does starting an erase, blank check or program. Read data appears one cycle after the read strobe. In status mode the read data is {8'h00, status}.
- R13: While an erase runs, only 0xB0 and 0x70 are accepted. While a blank check or program runs, only 0x70 is accepted, plus 0xD0 when the program was started inside a suspend.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_code | input | 8 | Command code, or don't-care on a program data write |
| cmd_addr | input | ADDR_W | Word address for commands and reads (block index in the top bits) |
| cmd_wdata | input | DATA_W | Program data |
| rd_en | input | 1 | Read strobe |
| vpp_low | input | 1 | Programming voltage at or below the lockout level |
| status | output | 8 | Status register: bit 7 ready, bit 6 erase suspended, bit 5 erase or blank-check failure, bit 3 voltage error |
| rd_data | output | DATA_W | Registered read data |
| cmd_reject | output | 1 | One-cycle pulse for a refused command or read |

## Verification
The assertions check, on every cycle:
- a suspension appears only right after a step boundary;
- a suspended controller always shows bits 7 and 6 set;
- an accepted resume clears both bits on the next cycle;
- a low voltage stops a running erase;
- error bit 5 is never lost without a Clear Status;
- no program write lands in the suspended block.

Some behaviours need the bench's scenarios, because they depend on data across whole command sequences:
- an erase that resumes still finishes with the block erased;
- a resume issued during a program waits for that program;
- an aborted erase leaves the array untouched;
- randomly programmed words read back as the AND of all data written to them.

// File: rtl/fec_pkg.sv
// Package: command codes and controller state shared by the erase controller.
// Assumes 8-bit command codes on the command bus.
package fec_pkg;

    localparam logic [7:0] OP_ERASE_SETUP = 8'h20;
    localparam logic [7:0] OP_CONFIRM     = 8'hD0;
    localparam logic [7:0] OP_SUSPEND     = 8'hB0;
    localparam logic [7:0] OP_READ_STATUS = 8'h70;
    localparam logic [7:0] OP_CLEAR_STAT  = 8'h50;
    localparam logic [7:0] OP_READ_ARRAY  = 8'hFF;
    localparam logic [7:0] OP_BLANK_SETUP = 8'hBC;
    localparam logic [7:0] OP_PROG_SETUP  = 8'h40;
    localparam logic [7:0] OP_READ_IDENT  = 8'h90;
    localparam logic [7:0] OP_READ_QUERY  = 8'h98;
    localparam logic [7:0] OP_LOCK_SETUP  = 8'h60;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ERASE_ARM,
        ST_BLANK_ARM,
        ST_PROG_ARM,
        ST_LOCK_ARM,
        ST_ERASING,
        ST_BLANKING,
        ST_PROGRAMMING,
        ST_SUSPENDED
    } fec_state_e;

endpackage

// File: rtl/fec_cmd_legal.sv
// Command legality decoder: decides whether a command write is accepted in
// the current controller state. Purely combinational. Assumes the caller
// has already compared the command block against the suspended block.
module fec_cmd_legal
    import fec_pkg::*;
(
    input  fec_state_e state,
    input  logic [7:0] cmd_code,
    input  logic       in_susp,
    input  logic       hits_susp_blk,
    output logic       accept
);

    // Accept table per state
    always_comb begin
        accept = 1'b0;
        case (state)
            ST_IDLE:
                accept = cmd_code inside {OP_ERASE_SETUP, OP_BLANK_SETUP, OP_PROG_SETUP,
                                          OP_LOCK_SETUP, OP_READ_STATUS, OP_CLEAR_STAT,
                                          OP_READ_ARRAY, OP_READ_IDENT, OP_READ_QUERY};
            ST_ERASE_ARM, ST_BLANK_ARM:
                accept = (cmd_code == OP_CONFIRM);
            ST_PROG_ARM:
                accept = !(in_susp && hits_susp_blk);
            ST_LOCK_ARM:
                accept = 1'b1;
            ST_ERASING:
                accept = cmd_code inside {OP_SUSPEND, OP_READ_STATUS};
            ST_BLANKING:
                accept = (cmd_code == OP_READ_STATUS);
            ST_PROGRAMMING:
                accept = (cmd_code == OP_READ_STATUS) || (in_susp && cmd_code == OP_CONFIRM);
            ST_SUSPENDED:
                accept = cmd_code inside {OP_READ_ARRAY, OP_READ_STATUS, OP_READ_IDENT,
                                          OP_READ_QUERY, OP_CONFIRM, OP_CLEAR_STAT,
                                          OP_PROG_SETUP, OP_SUSPEND, OP_LOCK_SETUP};
            default:
                accept = 1'b0;
        endcase
    end

endmodule

// File: rtl/fec_erase_seq.sv
// Erase step sequencer: counts NUM_STEPS steps of STEP_CYCLES cycles each.
// Marks every step boundary (checkpoint) and the final one. Holds its
// position while run is low, which is how a suspend keeps its progress.
// restart returns it to step 0.
module fec_erase_seq #(
    parameter int NUM_STEPS   = 4,
    parameter int STEP_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic checkpoint,
    output logic finished
);

    localparam int STEP_W = (NUM_STEPS > 1) ? $clog2(NUM_STEPS) : 1;
    localparam int CYC_W  = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
    localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(NUM_STEPS - 1);
    localparam logic [CYC_W-1:0]  CYC_LAST  = CYC_W'(STEP_CYCLES - 1);

    logic [STEP_W-1:0] step_q;
    logic [CYC_W-1:0]  cyc_q;

    // Boundary and completion flags
    always_comb begin
        checkpoint = run && (cyc_q == CYC_LAST);
        finished   = checkpoint && (step_q == STEP_LAST);
    end

    // Step and cycle counters, frozen while not running
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            step_q <= '0;
            cyc_q  <= '0;
        end else if (run) begin
            if (cyc_q == CYC_LAST) begin
                cyc_q  <= '0;
                step_q <= (step_q == STEP_LAST) ? '0 : step_q + 1'b1;
            end else begin
                cyc_q <= cyc_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/fec_array.sv
// Array model: NUM_BLOCKS blocks of WORDS words. Reset (and erase) leave
// words at all ones. A program ANDs data into a word. Provides a
// combinational read port and a per-block blank flag. Assumes program and
// erase are never requested in the same cycle.
module fec_array #(
    parameter int NUM_BLOCKS = 4,
    parameter int WORDS      = 8,
    parameter int DATA_W     = 16
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [$clog2(NUM_BLOCKS*WORDS)-1:0]   rd_addr,
    output logic [DATA_W-1:0]                     rd_word,
    input  logic                                  wr_en,
    input  logic [$clog2(NUM_BLOCKS*WORDS)-1:0]   wr_addr,
    input  logic [DATA_W-1:0]                     wr_data,
    input  logic                                  ers_en,
    input  logic [$clog2(NUM_BLOCKS)-1:0]         ers_blk,
    output logic [NUM_BLOCKS-1:0]                 blank_vec
);

    localparam int DEPTH  = NUM_BLOCKS * WORDS;
    localparam int WORD_W = $clog2(WORDS);

    logic [DATA_W-1:0] mem [DEPTH];

    // Combinational read
    assign rd_word = mem[rd_addr];

    // Storage update: reset to erased, block erase, or AND-program
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (ers_en) begin
            for (int w = 0; w < WORDS; w++) mem[{ers_blk, w[WORD_W-1:0]}] <= '1;
        end else if (wr_en) begin
            mem[wr_addr] <= mem[wr_addr] & wr_data;
        end
    end

    // One blank detector per block
    for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blank
        always_comb begin
            blank_vec[b] = 1'b1;
            for (int w = 0; w < WORDS; w++)
                if (mem[b*WORDS + w] != '1) blank_vec[b] = 1'b0;
        end
    end

endmodule

// File: rtl/fec_flash_ctrl.sv
// Erase controller top: command state machine, status register, read path
// and reject pulse. Assumes NUM_BLOCKS and WORDS are powers of two (at
// least 2), with the block index in the top address bits. The array
// resets to the erased state.
module fec_flash_ctrl
    import fec_pkg::*;
#(
    parameter int NUM_BLOCKS  = 4,
    parameter int WORDS       = 8,
    parameter int DATA_W      = 16,
    parameter int NUM_STEPS   = 4,
    parameter int STEP_CYCLES = 8,
    parameter int PROG_CYCLES = 5,
    localparam int ADDR_W     = $clog2(NUM_BLOCKS * WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [7:0]        cmd_code,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic              rd_en,
    input  logic              vpp_low,
    output logic [7:0]        status,
    output logic [DATA_W-1:0] rd_data,
    output logic              cmd_reject
);

    localparam int BLK_W   = $clog2(NUM_BLOCKS);
    localparam int OP_MAX  = (PROG_CYCLES > WORDS) ? PROG_CYCLES : WORDS;
    localparam int OPC_W   = $clog2(OP_MAX + 1);
    localparam logic [OPC_W-1:0] PROG_LAST  = OPC_W'(PROG_CYCLES - 1);
    localparam logic [OPC_W-1:0] BLANK_LAST = OPC_W'(WORDS - 1);

    fec_state_e        state;
    logic              in_susp, susp_req, resume_pend;
    logic              err_fail, err_vpp, mode_status;
    logic [BLK_W-1:0]  op_blk;
    logic [ADDR_W-1:0] prog_addr;
    logic [DATA_W-1:0] prog_data;
    logic [OPC_W-1:0]  op_cnt;
    logic [DATA_W-1:0] rd_data_q;
    logic              reject_q;

    logic [BLK_W-1:0]      cmd_blk;
    logic                  hits_susp_blk, legal_accept, rd_blocked;
    logic                  seq_run, seq_restart, seq_checkpoint, seq_finished;
    logic                  arr_wr_en, arr_ers_en;
    logic [DATA_W-1:0]     arr_word;
    logic [NUM_BLOCKS-1:0] blank_vec;
    logic                  busy;
    fec_state_e            ret_state;

    // Address decode and helper terms
    always_comb begin
        cmd_blk       = cmd_addr[ADDR_W-1 -: BLK_W];
        hits_susp_blk = (cmd_blk == op_blk);
        rd_blocked    = rd_en && !mode_status && in_susp && hits_susp_blk;
        ret_state     = in_susp ? ST_SUSPENDED : ST_IDLE;
        busy          = (state == ST_ERASING) || (state == ST_BLANKING) || (state == ST_PROGRAMMING);
        seq_run       = (state == ST_ERASING) && !vpp_low;
        seq_restart   = (state == ST_ERASE_ARM) && cmd_we && legal_accept;
        arr_wr_en     = (state == ST_PROGRAMMING) && (op_cnt == PROG_LAST);
        arr_ers_en    = (state == ST_ERASING) && seq_finished;
    end

    fec_cmd_legal u_legal (
        .state         (state),
        .cmd_code      (cmd_code),
        .in_susp       (in_susp),
        .hits_susp_blk (hits_susp_blk),
        .accept        (legal_accept)
    );

    fec_erase_seq #(
        .NUM_STEPS   (NUM_STEPS),
        .STEP_CYCLES (STEP_CYCLES)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (seq_restart),
        .run        (seq_run),
        .checkpoint (seq_checkpoint),
        .finished   (seq_finished)
    );

    fec_array #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .WORDS      (WORDS),
        .DATA_W     (DATA_W)
    ) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_addr   (cmd_addr),
        .rd_word   (arr_word),
        .wr_en     (arr_wr_en),
        .wr_addr   (prog_addr),
        .wr_data   (prog_data),
        .ers_en    (arr_ers_en),
        .ers_blk   (op_blk),
        .blank_vec (blank_vec)
    );

    // Command state machine, suspend bookkeeping and error bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            in_susp     <= 1'b0;
            susp_req    <= 1'b0;
            resume_pend <= 1'b0;
            err_fail    <= 1'b0;
            err_vpp     <= 1'b0;
            mode_status <= 1'b0;
            op_blk      <= '0;
            prog_addr   <= '0;
            prog_data   <= '0;
            op_cnt      <= '0;
        end else begin
            case (state)
                ST_IDLE, ST_SUSPENDED: begin
                    if (cmd_we && legal_accept) begin
                        case (cmd_code)
                            OP_ERASE_SETUP: begin state <= ST_ERASE_ARM; mode_status <= 1'b1; end
                            OP_BLANK_SETUP: begin state <= ST_BLANK_ARM; mode_status <= 1'b1; end
                            OP_PROG_SETUP:  begin state <= ST_PROG_ARM;  mode_status <= 1'b1; end
                            OP_LOCK_SETUP:  state <= ST_LOCK_ARM;
                            OP_READ_STATUS, OP_READ_IDENT, OP_READ_QUERY: mode_status <= 1'b1;
                            OP_READ_ARRAY:  mode_status <= 1'b0;
                            OP_CLEAR_STAT: begin err_fail <= 1'b0; err_vpp <= 1'b0; end
                            OP_CONFIRM: begin
                                state       <= ST_ERASING;
                                in_susp     <= 1'b0;
                                susp_req    <= 1'b0;
                                mode_status <= 1'b1;
                            end
                            default: ;
                        endcase
                    end
                end
                ST_ERASE_ARM: begin
                    if (cmd_we) begin
                        if (!legal_accept) begin
                            state <= ST_IDLE;
                        end else if (vpp_low) begin
                            err_vpp <= 1'b1;
                            state   <= ST_IDLE;
                        end else begin
                            op_blk <= cmd_blk;
                            state  <= ST_ERASING;
                        end
                    end
                end
                ST_BLANK_ARM: begin
                    if (cmd_we) begin
                        if (legal_accept) begin
                            op_blk <= cmd_blk;
                            op_cnt <= '0;
                            state  <= ST_BLANKING;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_PROG_ARM: begin
                    if (cmd_we) begin
                        if (legal_accept && !vpp_low) begin
                            prog_addr <= cmd_addr;
                            prog_data <= cmd_wdata;
                            op_cnt    <= '0;
                            state     <= ST_PROGRAMMING;
                        end else begin
                            if (legal_accept) err_vpp <= 1'b1;
                            state <= ret_state;
                        end
                    end
                end
                ST_LOCK_ARM: begin
                    if (cmd_we) state <= ret_state;
                end
                ST_ERASING: begin
                    if (cmd_we && legal_accept && cmd_code == OP_SUSPEND) susp_req <= 1'b1;
                    if (vpp_low) begin
                        err_vpp  <= 1'b1;
                        susp_req <= 1'b0;
                        state    <= ST_IDLE;
                    end else if (seq_finished) begin
                        susp_req <= 1'b0;
                        state    <= ST_IDLE;
                    end else if (susp_req && seq_checkpoint) begin
                        susp_req <= 1'b0;
                        in_susp  <= 1'b1;
                        state    <= ST_SUSPENDED;
                    end
                end
                ST_BLANKING: begin
                    op_cnt <= op_cnt + 1'b1;
                    if (op_cnt == BLANK_LAST) begin
                        if (!blank_vec[op_blk]) err_fail <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                ST_PROGRAMMING: begin
                    op_cnt <= op_cnt + 1'b1;
                    if (cmd_we && legal_accept && cmd_code == OP_CONFIRM) resume_pend <= 1'b1;
                    if (op_cnt == PROG_LAST) begin
                        if (resume_pend || (cmd_we && legal_accept && cmd_code == OP_CONFIRM)) begin
                            resume_pend <= 1'b0;
                            in_susp     <= 1'b0;
                            state       <= ST_ERASING;
                        end else begin
                            state <= ret_state;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Registered read data and reject pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_q <= '0;
            reject_q  <= 1'b0;
        end else begin
            reject_q <= (cmd_we && !legal_accept) || rd_blocked;
            if (rd_en) begin
                if (mode_status)     rd_data_q <= DATA_W'(status);
                else if (rd_blocked) rd_data_q <= '0;
                else                 rd_data_q <= arr_word;
            end
        end
    end

    // Status register assembly
    always_comb begin
        status = {!busy, in_susp && !resume_pend, err_fail, 1'b0, err_vpp, 3'b000};
    end

    assign rd_data    = rd_data_q;
    assign cmd_reject = reject_q;

endmodule

// File: rtl/fec_flash_ctrl_chk.sv
// Assertion checker for fec_flash_ctrl, attached by bind. It watches the
// ports together with the controller state, the sequencer checkpoint and
// the array write strobe.
module fec_flash_ctrl_chk
    import fec_pkg::*;
#(
    parameter int BLK_W  = 2,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_we,
    input logic [7:0]        cmd_code,
    input logic              vpp_low,
    input logic [7:0]        status,
    input logic              cmd_reject,
    input fec_state_e        state,
    input logic              legal_accept,
    input logic              seq_checkpoint,
    input logic              arr_wr_en,
    input logic              in_susp,
    input logic [ADDR_W-1:0] prog_addr,
    input logic [BLK_W-1:0]  op_blk
);

    AST_ERASE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_ERASING |-> !status[7]); // R1

    AST_SUSP_AT_CHECKPOINT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[6]) |-> $past(seq_checkpoint)); // R4

    AST_SUSP_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_SUSPENDED |-> (status[7] && status[6])); // R4

    AST_BAD_IN_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && state == ST_SUSPENDED && (cmd_code == OP_ERASE_SETUP || cmd_code == OP_BLANK_SETUP))
        |=> cmd_reject); // R5

    AST_SUSP_BLOCK_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_wr_en && in_susp) |-> (prog_addr[ADDR_W-1 -: BLK_W] != op_blk)); // R6

    AST_RESUME_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && legal_accept && cmd_code == OP_CONFIRM && state == ST_SUSPENDED)
        |=> (!status[7] && !status[6])); // R7

    AST_VPP_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERASING && vpp_low) |=> (state != ST_ERASING && status[3])); // R8

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status[5] && !(cmd_we && legal_accept && cmd_code == OP_CLEAR_STAT)) |=> status[5]); // R9

endmodule

bind fec_flash_ctrl fec_flash_ctrl_chk #(
    .BLK_W  (BLK_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_we         (cmd_we),
    .cmd_code       (cmd_code),
    .vpp_low        (vpp_low),
    .status         (status),
    .cmd_reject     (cmd_reject),
    .state          (state),
    .legal_accept   (legal_accept),
    .seq_checkpoint (seq_checkpoint),
    .arr_wr_en      (arr_wr_en),
    .in_susp        (in_susp),
    .prog_addr      (prog_addr),
    .op_blk         (op_blk)
);

// File: tb/fec_flash_ctrl_bench.sv
// Bench for fec_flash_ctrl: directed erase/suspend/resume sequences plus
// seeded random programs and random command codes issued while suspended.
module fec_flash_ctrl_bench;

    localparam int ADDR_W = 5;
    localparam int DATA_W = 16;
    localparam int STEP_CYCLES = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_we = 1'b0;
    logic [7:0]        cmd_code = '0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [DATA_W-1:0] cmd_wdata = '0;
    logic              rd_en = 1'b0;
    logic              vpp_low = 1'b0;
    logic [7:0]        status;
    logic [DATA_W-1:0] rd_data;
    logic              cmd_reject;

    int n_cmp = 0;
    int n_bad = 0;
    logic              last_rej;
    logic [DATA_W-1:0] last_rd;
    logic [DATA_W-1:0] shm [32];

    always #2.5 clk = ~clk;

    fec_flash_ctrl #(.STEP_CYCLES(STEP_CYCLES)) u_fec_flash_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_code(cmd_code),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .rd_en(rd_en),
        .vpp_low(vpp_low), .status(status), .rd_data(rd_data), .cmd_reject(cmd_reject)
    );

    function automatic bit legal_in_susp(input logic [7:0] c);
        return c inside {8'hFF, 8'h70, 8'h90, 8'h98, 8'hD0, 8'h50, 8'h40, 8'hB0, 8'h60};
    endfunction

    function automatic logic [DATA_W-1:0] prog_result(input logic [DATA_W-1:0] old, input logic [DATA_W-1:0] d);
        return old & d;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] c, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        cmd_we = 1'b1; cmd_code = c; cmd_addr = a; cmd_wdata = d;
        @(negedge clk);
        cmd_we = 1'b0;
        last_rej = cmd_reject;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a);
        @(negedge clk);
        rd_en = 1'b1; cmd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        last_rd = rd_data; last_rej = cmd_reject;
    endtask

    task automatic wait_bit(input int b, input int lim, output int cyc);
        cyc = 0;
        while (status[b] !== 1'b1 && cyc < lim) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic prog(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        int c;
        wr(8'h40, a, '0);
        wr(8'h00, a, d);
        wait_bit(7, 100, c);
        shm[a] = prog_result(shm[a], d);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        int cyc;
        logic [7:0] c;
        logic [ADDR_W-1:0] a;
        logic [DATA_W-1:0] d;
        void'($urandom(32'd1357));
        for (int i = 0; i < 32; i++) shm[i] = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset status", status, 8'h80);

        // R12: array and status read modes
        rd(5'd0);
        chk("R12 array read", last_rd, 16'hFFFF);
        wr(8'h70, 0, 0);
        rd(5'd0);
        chk("R12 status read", last_rd, 16'h0080);

        // R11: random programs into blocks 0..2, block 3 kept blank
        prog(5'd1, 16'h00FF);
        for (int i = 0; i < 20; i++) begin
            a = ADDR_W'($urandom % 24);
            d = DATA_W'($urandom);
            prog(a, d);
        end
        rd(5'd1);
        chk("R12 status mode after program", last_rd, 16'h0080);
        wr(8'hFF, 0, 0);
        for (int i = 0; i < 24; i++) begin
            rd(ADDR_W'(i));
            chk("R11 programmed word", last_rd, shm[i]);
        end

        // R2: wrong confirm after erase setup
        wr(8'h20, 5'd0, 0);
        wr(8'h70, 5'd0, 0);
        chk("R2 bad confirm rejected", last_rej, 1'b1);
        wr(8'hFF, 0, 0);
        rd(5'd1);
        chk("R2 no erase on bad confirm", last_rd, shm[1]);

        // R3/R9: blank check failure, stickiness, clear, pass
        wr(8'hBC, 5'd0, 0);
        wr(8'hD0, 5'd0, 0);
        wr(8'hFF, 5'd0, 0);
        chk("R13 read array refused during blank check", last_rej, 1'b1);
        wait_bit(7, 100, cyc);
        chk("R3 blank check fail", status, 8'hA0);
        wr(8'hBC, 5'd24, 0);
        wr(8'hD0, 5'd24, 0);
        wait_bit(7, 100, cyc);
        chk("R9 fail bit sticky", status, 8'hA0);
        wr(8'h50, 0, 0);
        chk("R9 clear status", status, 8'h80);
        wr(8'hBC, 5'd24, 0);
        wr(8'hD0, 5'd24, 0);
        wait_bit(7, 100, cyc);
        chk("R3 blank block passes", status, 8'h80);

        // R4: erase block 0 and suspend at an arbitrary address
        wr(8'h20, 5'd0, 0);
        wr(8'hD0, 5'd2, 0);
        chk("R1 busy during erase", status[7], 1'b0);
        wr(8'hFF, 5'd0, 0);
        chk("R13 read array refused during erase", last_rej, 1'b1);
        wr(8'hB0, 5'd31, 0);
        chk("R4 suspend accepted", last_rej, 1'b0);
        chk("R4 busy until checkpoint", status & 8'hC0, 8'h00);
        wait_bit(6, 100, cyc);
        chk("R4 suspend within one step", cyc <= STEP_CYCLES, 1);
        chk("R4 suspended status", status, 8'hC0);

        // R5: random command codes while suspended
        for (int i = 0; i < 16; i++) begin
            case ($urandom % 12)
                0: c = 8'h20;  1: c = 8'hBC;  2: c = 8'hFF;  3: c = 8'h70;
                4: c = 8'h90;  5: c = 8'h98;  6: c = 8'h50;  7: c = 8'hB0;
                8: c = 8'h60;  9: c = 8'hE8;  10: c = 8'h41; default: c = 8'h10;
            endcase
            wr(c, ADDR_W'($urandom), 0);
            chk("R5 legality while suspended", last_rej, !legal_in_susp(c));
            if (c == 8'h60) wr(8'h01, 0, 0);
        end
        chk("R5 still suspended", status, 8'hC0);

        // R6: suspended block guarded, others usable
        wr(8'hFF, 0, 0);
        rd(5'd1);
        chk("R6 read suspended block rejected", last_rej, 1'b1);
        chk("R6 read suspended block data", last_rd, 16'h0000);
        rd(5'd9);
        chk("R6 read other block", last_rd, shm[9]);
        wr(8'h40, 5'd3, 0);
        wr(8'h00, 5'd3, 16'h0000);
        chk("R6 program suspended block rejected", last_rej, 1'b1);
        chk("R6 status unchanged", status, 8'hC0);

        // R7: program in another block, then resume during the program
        wr(8'h40, 5'd16, 0);
        wr(8'h00, 5'd16, 16'h0F0F);
        wr(8'hD0, 5'd7, 0);
        chk("R7 resume accepted", last_rej, 1'b0);
        chk("R7 resume clears bits 7 and 6", status & 8'hC0, 8'h00);
        shm[16] = prog_result(shm[16], 16'h0F0F);
        wait_bit(7, 200, cyc);
        for (int i = 0; i < 8; i++) shm[i] = '1;
        chk("R7 erase completed", status, 8'h80);
        wr(8'hFF, 0, 0);
        rd(5'd1);
        chk("R2 erased word", last_rd, 16'hFFFF);
        rd(5'd7);
        chk("R2 erased last word", last_rd, 16'hFFFF);
        rd(5'd16);
        chk("R7 program finished before resume", last_rd, shm[16]);

        // R8: low voltage halts erase of block 1 and blocks a program
        prog(5'd8, 16'h1234);
        wr(8'h20, 5'd8, 0);
        wr(8'hD0, 5'd8, 0);
        @(negedge clk); vpp_low = 1'b1;
        @(negedge clk); @(negedge clk); vpp_low = 1'b0;
        chk("R8 erase halted with voltage error", status, 8'h88);
        wr(8'hFF, 0, 0);
        rd(5'd8);
        chk("R8 block untouched", last_rd, shm[8]);
        wr(8'h50, 0, 0);
        chk("R9 clear voltage error", status, 8'h80);
        vpp_low = 1'b1;
        wr(8'h40, 5'd9, 0);
        wr(8'h00, 5'd9, 16'h0000);
        vpp_low = 1'b0;
        chk("R8 program refused at low voltage", status, 8'h88);
        wr(8'hFF, 0, 0);
        rd(5'd9);
        chk("R8 word unchanged", last_rd, shm[9]);
        wr(8'h50, 0, 0);

        // R10: reset aborts a suspended erase
        wr(8'h20, 5'd16, 0);
        wr(8'hD0, 5'd16, 0);
        wr(8'hB0, 5'd0, 0);
        wait_bit(6, 100, cyc);
        chk("R10 suspended before reset", status, 8'hC0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R10 status after reset", status, 8'h80);
        wr(8'hD0, 5'd16, 0);
        chk("R10 resume rejected after reset", last_rej, 1'b1);

        summary();
    end

endmodule